// File: doc/BRIEF.md
# 32-bit Integer ALU with Signed Set-Less-Than

This block is the combinational arithmetic logic unit of a simple load/store RISC core. It takes two operands and a 3-bit operation code. It returns a result word, a flag that is high when the result is all zeros, and a signed overflow flag. It supports bitwise AND, bitwise OR, addition, subtraction and a signed set-less-than compare.

The datapath is a row of identical bit slices. Each slice has a full adder, an AND gate, an OR gate and a result selector. Subtraction reuses the adder. The top opcode bit inverts operand B and injects a carry of 1 into the lowest slice, so the adder forms A + ~B + 1.

For the compare, the sign information is taken from the most significant slice and fed back into bit 0 of the result. The decode logic uses the zero flag after a subtraction to test two registers for equality. The overflow flag is only reported and raises no exception.

Top module: `alu32`

## Requirements
- R1: Opcode 000 gives the bitwise AND of the operands, and opcode 001 gives the bitwise OR.
- R2: Opcode 010 gives A + B modulo 2^32.
- R3: Opcode 110 gives A − B modulo 2^32.
- R4: Opcode 111 sets result bit 0 to 1 exactly when A < B as signed two's-complement numbers. This holds even when A − B overflows. Result bits 31..1 are 0.
- R5: The zero output is 1 exactly when all 32 result bits are 0. Opcode 110 with equal operands therefore raises it.
- R6: Under opcode 010, the overflow output is 1 when both operands have the same sign bit and the sum's sign bit differs from it. Operands of opposite sign never flag overflow.
- R7: Under opcode 110, the overflow output is 1 when the operand sign bits differ and the difference's sign bit differs from A's. Operands of equal sign never flag overflow.
- R8: The overflow output is 0 under opcodes 000, 001 and 111.
- R9: Opcodes 011, 100 and 101 give a zero result, zero output 1 and overflow 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opcode | input | 3 | Operation select; bit 2 inverts B and sets carry-in |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
Two pairs of functions can occur on the same evaluation.

The first pair is the signed compare and subtraction overflow. The compare must invert the raw difference sign exactly when A − B overflows. The vectors 0x80000000 against 0x7FFFFFFF, and the reverse, force that case. A correct block answers 1 and 0 there, while a sign-only compare gives the opposite.

The second pair is the zero flag and overflow. Adding 0x80000000 to itself, or 0xFFFFFFFF to 1, wraps to zero. The first sum must raise both flags together, and the second must raise only zero.

Every vector, whether from the directed table or from the random operands, is judged against a behavioural model. That model uses wide arithmetic and signed comparison, not a slice structure.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   opcode,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         overflow
);
  localparam int MSB = W - 1;

  logic         negb;
  logic [W-1:0] binv;
  logic [W-1:0] sum;
  logic [W-1:0] slice_out;
  logic         cin_top, cout_top;
  logic         ovf_raw, less, arith_op, valid_op;

  assign negb = opcode[2];
  assign binv = opb ^ {W{negb}};

  always_comb begin
    logic c;
    c = negb;
    cin_top = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i == MSB) cin_top = c;
      sum[i] = opa[i] ^ binv[i] ^ c;
      c = (opa[i] & binv[i]) | (opa[i] & c) | (binv[i] & c);
    end
    cout_top = c;
  end

  assign ovf_raw = cout_top ^ cin_top;
  assign less    = sum[MSB] ^ ovf_raw;

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      logic less_in;
      if (i == 0) begin : g_lsb
        assign less_in = less;
      end else begin : g_rest
        assign less_in = 1'b0;
      end
      assign slice_out[i] = (opcode[1:0] == 2'b00) ? (opa[i] & binv[i]) :
                            (opcode[1:0] == 2'b01) ? (opa[i] | binv[i]) :
                            (opcode[1:0] == 2'b10) ? sum[i] : less_in;
    end
  endgenerate

  assign valid_op = (opcode == 3'b000) || (opcode == 3'b001) || (opcode == 3'b010) ||
                    (opcode == 3'b110) || (opcode == 3'b111);
  assign arith_op = (opcode == 3'b010) || (opcode == 3'b110);

  assign result   = valid_op ? slice_out : '0;
  assign overflow = arith_op & ovf_raw;
  assign zero     = ~|result;
endmodule

// File: rtl/alu32_props.sv
module alu32_props #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   opcode,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         overflow
);
  always_comb begin
    if (opcode == 3'b010)
      AST_ADD_SUM: assert (result == opa + opb) else $error("add mismatch"); // R2
    if (opcode == 3'b110)
      AST_SUB_DIFF: assert (result == opa - opb) else $error("sub mismatch"); // R3
    if (opcode == 3'b111)
      AST_SLT_UPPER_CLEAR: assert (result[W-1:1] == '0) else $error("slt upper bits"); // R4
    if (opcode == 3'b110 && opa == opb)
      AST_EQUAL_SETS_ZERO: assert (zero) else $error("equal sub not zero"); // R5
    if (opcode == 3'b010 && opa[W-1] != opb[W-1])
      AST_NO_OVERFLOW_MIXED_ADD: assert (!overflow) else $error("mixed add ovf"); // R6
    if (opcode == 3'b110 && opa[W-1] == opb[W-1])
      AST_NO_OVERFLOW_LIKE_SUB: assert (!overflow) else $error("like sub ovf"); // R7
    if (opcode == 3'b000 || opcode == 3'b001 || opcode == 3'b111)
      AST_NO_OVERFLOW_LOGIC: assert (!overflow) else $error("logic ovf"); // R8
    if (opcode == 3'b011 || opcode == 3'b100 || opcode == 3'b101)
      AST_UNUSED_QUIET: assert (result == '0 && !overflow) else $error("unused op"); // R9
  end
endmodule

bind alu32 alu32_props #(.W(W)) u_props (
  .opa(opa), .opb(opb), .opcode(opcode),
  .result(result), .zero(zero), .overflow(overflow)
);

// File: tb/sim_alu32.sv
module sim_alu32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b, r;
  logic [2:0]  op;
  logic        z, v;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  alu32 u0 (.opa(a), .opb(b), .opcode(op), .result(r), .zero(z), .overflow(v));

  // {op, a, b, result, zero, overflow}
  localparam logic [100:0] VEC [18] = '{
    {3'b000, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 1'b0, 1'b0},
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 1'b0, 1'b0},
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1},
    {3'b010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
    {3'b010, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b0, 1'b1},
    {3'b010, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0},
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1},
    {3'b110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1},
    {3'b110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0},
    {3'b110, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b0},
    {3'b111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0},
    {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0},
    {3'b111, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0, 1'b0},
    {3'b111, 32'h00000003, 32'h00000003, 32'h00000000, 1'b1, 1'b0},
    {3'b011, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
    {3'b100, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0},
    {3'b101, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b0}
  };

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'b000:  return "R1 R5 R8";
      3'b001:  return "R1 R8";
      3'b010:  return "R2 R5 R6";
      3'b110:  return "R3 R5 R7";
      3'b111:  return "R4 R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [33:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] s;
    logic        ov;
    ov = 1'b0;
    case (o)
      3'b000: s = x & y;
      3'b001: s = x | y;
      3'b010: begin s = x + y; ov = (x[31] == y[31]) && (s[31] != x[31]); end
      3'b110: begin s = x - y; ov = (x[31] != y[31]) && (s[31] != x[31]); end
      3'b111: s = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: s = 32'd0;
    endcase
    return {s, (s == 32'd0), ov};
  endfunction

  task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [33:0] exp, input string tag);
    @(posedge clk);
    #1 op = o; a = x; b = y;
    @(negedge clk);
    n_checks++;
    if ({r, z, v} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h: got r=%h z=%b v=%b, expected r=%h z=%b v=%b",
               tag, o, x, y, r, z, v, exp[33:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    op = 3'b000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (r !== 32'd0 || z !== 1'b1 || v !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 reset idle: got r=%h z=%b v=%b, expected r=0 z=1 v=0", r, z, v);
    end
    rst = 1'b0;

    for (int k = 0; k < 18; k++) begin
      logic [100:0] e;
      e = VEC[k];
      apply(e[100:98], e[97:66], e[65:34], e[33:0], req_of(e[100:98]));
    end

    // R4 compare across overflow, R5 equality via subtract, R9 unused ops
    apply(3'b111, 32'h80000000, 32'h00000001, model(3'b111, 32'h80000000, 32'h00000001), "R4");
    apply(3'b110, 32'hDEADBEEF, 32'hDEADBEEF, {32'd0, 1'b1, 1'b0}, "R5");
    apply(3'b100, 32'h12345678, 32'h9ABCDEF0, {32'd0, 1'b1, 1'b0}, "R9");

    for (int k = 0; k < 3000; k++) begin
      logic [2:0]  o;
      logic [31:0] x, y;
      o = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: x = 32'h7FFFFFFF;
        1: x = 32'h80000000;
        2: x = 32'h00000000;
        3: x = 32'hFFFFFFFF;
        default: x = $urandom;
      endcase
      case ($urandom_range(0, 5))
        0: y = 32'h7FFFFFFF;
        1: y = 32'h80000000;
        2: y = 32'h00000000;
        3: y = 32'hFFFFFFFF;
        4: y = x;
        default: y = $urandom;
      endcase
      apply(o, x, y, model(o, x, y), req_of(o));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule